// File: doc/BRIEF.md
# Byte-wide SPI master with idle-high serial clock

This block moves one byte in each direction between the chip and an SPI peripheral. The caller presents a byte, a peripheral index and a clock divider, then pulses `start`. The block drives the indexed active-low select line low and waits half a serial-clock period. It then produces eight serial-clock cycles and ends with a trailing half period. The serial clock rests high and toggles only while a byte is in flight.

Outgoing bits change on each falling edge, most significant bit first. Incoming bits are taken at each rising edge. Receiving therefore always costs a transmitted byte, even a dummy one. When the last half period has passed, the received byte appears on `rx_byte` and `done` pulses for one cycle.

If the caller sets `keep_cs` when it starts a transfer, the select line stays low after that transfer. The next byte then joins the same frame.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, all select lines are high, `sclk` is high, `busy` and `done` are low and `rx_byte` is zero.
- R2: `sclk` rests high whenever the block is idle. It changes only while `busy` is high, and each transfer has exactly eight falling and eight rising edges.
- R3: Each half period of `sclk` lasts `clk_div`+1 system clocks, so the serial period is 2×(`clk_div`+1). The value of `clk_div` is taken when the transfer starts.
- R4: `mosi` carries `tx_byte` most significant bit first. While a transfer runs, `mosi` changes only on a falling edge of `sclk`.
- R5: `miso` is sampled on each rising edge of `sclk`, first bit into the most significant position. The assembled byte appears on `rx_byte` in the cycle that `done` is high and is held until the next transfer ends.
- R6: At most one select line is low at any time. During a transfer the low line is `cs_n[cs_sel]`, with `cs_sel` taken when the transfer starts.
- R7: The select line falls one half period before the first falling edge of `sclk`. Unless it is held (R10), it rises one half period after the last rising edge, in the same cycle that `done` goes high.
- R8: A `start` that arrives while `busy` is high has no effect. Changes to `tx_byte`, `cs_sel`, `clk_div` and `keep_cs` during a transfer have no effect either.
- R9: `busy` goes high on the cycle after an accepted `start`. `done` is a single-cycle pulse that comes 17×(`clk_div`+1) cycles after `busy` rises, and `busy` is low in that cycle.
- R10: A transfer started with `keep_cs` high leaves its select line low after `done`. A transfer started with `keep_cs` low releases the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one byte transfer (taken only when idle) |
| cs_sel | input | $clog2(N_CS) | Index of the peripheral to select |
| keep_cs | input | 1 | Hold the select line low after this byte |
| clk_div | input | DIV_W | Half-period length minus one, in system clocks |
| tx_byte | input | WORD_W | Byte to send |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Gated serial clock, idle high |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | N_CS | Active-low select lines, one per peripheral |
| busy | output | 1 | A transfer is in flight |
| done | output | 1 | One-cycle pulse when `rx_byte` is valid |
| rx_byte | output | WORD_W | Last received byte |

## Verification
The hardest case to reach from the ports is a second request that lands in the middle of shifting. That request comes with new values on every configuration input, and the block must ignore all of them. The stimulus waits until the second falling edge of `sclk`, then pulses `start` with an inverted byte, another select index, another divider and the opposite hold flag. It then checks that the timing, both data bytes and the select line match the first request. The held-select case needs two transfers back to back on one line: the first sets `keep_cs` and the second clears it, and the bench watches the line after each `done`.

// File: rtl/spi_mstr_pkg.sv
// Shared types for the byte SPI master.
// Assumes: nothing beyond the four-phase transfer sequence below.
package spi_mstr_pkg;

    // Transfer phases: idle, select lead-in, shifting, select trail-out
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } xfer_state_t;

endpackage

// File: rtl/spi_half_tick.sv
// Half-period timer: while run is high, counts system clocks and pulses
// tick every (limit+1) clocks. Held at zero while run is low, so the first
// tick after run rises comes exactly limit+1 clocks later.
// Assumes: limit is stable while run is high.
module spi_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    // Count clocks within one half period; clear when stopped or on wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_shift_pair.sv
// Transmit and receive shift registers. The transmit side presents its MSB
// and moves left on adv_out. The receive side takes sin into its LSB on adv_in.
// Assumes: load never coincides with adv_out or adv_in.
module spi_shift_pair #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv_out,
    input  logic         adv_in,
    input  logic         sin,
    output logic         sout,
    output logic [W-1:0] rx_val
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    assign sout   = tx_q[W-1];
    assign rx_val = rx_q;

    // Outgoing register: load at start, shift left at each launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (adv_out) begin
            tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end

    // Incoming register: clear at start, append one bit at each capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load) begin
            rx_q <= '0;
        end else if (adv_in) begin
            rx_q <= {rx_q[W-2:0], sin};
        end
    end

endmodule

// File: rtl/spi_cs_select.sv
// Active-low select lines. On set, only the indexed line goes low and all
// others go high. On rel, every line goes high. Each line is its own flop.
// Assumes: set and rel are never high together.
module spi_cs_select #(
    parameter int N_CS  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic [SEL_W-1:0] sel,
    input  logic             rel,
    output logic [N_CS-1:0]  cs_n
);

    for (genvar g = 0; g < N_CS; g++) begin : g_line
        logic line_q;

        // Drive this line low only when it is the chosen one
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q <= 1'b1;
            end else if (set) begin
                line_q <= (sel != SEL_W'(g));
            end else if (rel) begin
                line_q <= 1'b1;
            end
        end

        assign cs_n[g] = line_q;
    end

endmodule

// File: rtl/spi_byte_master.sv
// Byte SPI master with a gated serial clock that idles high.
// Sequence: select low, wait one half period, then 8 falling/rising pairs
// (launch on falling, capture on rising), wait one half period, then done
// and release the select line unless it is held.
// Assumes: miso settles within one half period after a falling edge.
module spi_byte_master
    import spi_mstr_pkg::*;
#(
    parameter int N_CS   = 4,
    parameter int DIV_W  = 8,
    parameter int WORD_W = 8,
    localparam int SEL_W = (N_CS > 1) ? $clog2(N_CS) : 1,
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  cs_sel,
    input  logic              keep_cs,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [N_CS-1:0]   cs_n,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_byte
);

    xfer_state_t       state_q;
    logic [DIV_W-1:0]  div_q;
    logic              keep_q;
    logic [BIT_W-1:0]  bit_q;
    logic              sclk_q;
    logic              done_q;
    logic [WORD_W-1:0] rx_byte_q;

    logic              tick;
    logic              accept;
    logic              launch;
    logic              capture;
    logic              release_cs;
    logic [WORD_W-1:0] rx_val;

    assign accept     = start && (state_q == ST_IDLE);
    assign launch     = (state_q == ST_SHIFT) && tick && sclk_q;
    assign capture    = (state_q == ST_SHIFT) && tick && !sclk_q;
    assign release_cs = (state_q == ST_TRAIL) && tick && !keep_q;

    assign busy    = (state_q != ST_IDLE);
    assign sclk    = sclk_q;
    assign done    = done_q;
    assign rx_byte = rx_byte_q;

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .limit (div_q),
        .tick  (tick)
    );

    spi_shift_pair #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (tx_byte),
        .adv_out  (launch),
        .adv_in   (capture),
        .sin      (miso),
        .sout     (mosi),
        .rx_val   (rx_val)
    );

    spi_cs_select #(.N_CS(N_CS), .SEL_W(SEL_W)) u_cs (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (accept),
        .sel   (cs_sel),
        .rel   (release_cs),
        .cs_n  (cs_n)
    );

    // Phase sequencing, serial clock level, bit count and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            div_q     <= '0;
            keep_q    <= 1'b0;
            bit_q     <= '0;
            sclk_q    <= 1'b1;
            done_q    <= 1'b0;
            rx_byte_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_LEAD;
                        div_q   <= clk_div;
                        keep_q  <= keep_cs;
                        bit_q   <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk_q  <= 1'b0;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            if (bit_q == BIT_W'(WORD_W - 1)) begin
                                state_q <= ST_TRAIL;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end else begin
                            sclk_q <= 1'b0;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        state_q   <= ST_IDLE;
                        done_q    <= 1'b1;
                        rx_byte_q <= rx_val;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_byte_master_chk.sv
// Protocol checker for spi_byte_master, bound to every instance.
// Tracks the half-period length with its own counter rather than a deep $past.
module spi_byte_master_chk #(
    parameter int N_CS  = 4,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [DIV_W-1:0] clk_div,
    input logic             sclk,
    input logic             mosi,
    input logic [N_CS-1:0]  cs_n,
    input logic             busy,
    input logic             done
);

    logic [DIV_W:0] hc_q;
    logic [DIV_W:0] lim_q;
    logic           sc_q;

    // Clocks since the last serial-clock change, and the expected half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q  <= '0;
            lim_q <= '0;
            sc_q  <= 1'b1;
        end else begin
            sc_q <= sclk;
            if (start && !busy) begin
                hc_q  <= '0;
                lim_q <= {1'b0, clk_div} + 1'b1;
            end else if (sclk != sc_q) begin
                hc_q <= 1;
            end else if (hc_q != '1) begin
                hc_q <= hc_q + 1'b1;
            end
        end
    end

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    a_r2_toggle_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> busy);

    a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != sc_q) |-> (hc_q == lim_q));

    a_r4_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable(mosi)) |-> $fell(sclk));

    a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind spi_byte_master spi_byte_master_chk #(.N_CS(N_CS), .DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .clk_div (clk_div),
    .sclk    (sclk),
    .mosi    (mosi),
    .cs_n    (cs_n),
    .busy    (busy),
    .done    (done)
);

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cs_sel = 2'd0;
    logic       keep_cs = 1'b0;
    logic [7:0] clk_div = 8'd0;
    logic [7:0] tx_byte = 8'd0;
    logic       miso = 1'b0;
    logic       sclk;
    logic       mosi;
    logic [3:0] cs_n;
    logic       busy;
    logic       done;
    logic [7:0] rx_byte;

    always #4 clk = ~clk;

    spi_byte_master #(.N_CS(4), .DIV_W(8), .WORD_W(8)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cs_sel  (cs_sel),
        .keep_cs (keep_cs),
        .clk_div (clk_div),
        .tx_byte (tx_byte),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .cs_n    (cs_n),
        .busy    (busy),
        .done    (done),
        .rx_byte (rx_byte)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Peripheral model: launches on falling edges, captures on rising edges
    logic [7:0] s_tx = 8'd0;
    logic [7:0] s_rx = 8'd0;
    int         s_idx = 7;

    always @(negedge sclk) begin
        if (cs_n != 4'hF && s_idx >= 0) begin
            miso = s_tx[s_idx[2:0]];
            s_idx--;
        end
    end

    always @(posedge sclk) begin
        if (cs_n != 4'hF) s_rx = {s_rx[6:0], mosi};
    end

    // Edge and timing monitor, sampling between active clock edges
    int         cyc = 0;
    int         n_fall, n_rise, t_busy, t_ff, t_lr, t_done, done_w;
    bit         busy_at_done;
    logic [3:0] cs_at_fall;
    logic       prev_sclk = 1'b1;
    logic       prev_busy = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_sclk === 1'b1 && sclk === 1'b0) begin
                n_fall++;
                if (n_fall == 1) begin
                    t_ff = cyc;
                    cs_at_fall = cs_n;
                end
            end
            if (prev_sclk === 1'b0 && sclk === 1'b1) begin
                n_rise++;
                t_lr = cyc;
            end
            if (busy && !prev_busy) t_busy = cyc;
            if (done) begin
                done_w++;
                if (done_w == 1) begin
                    t_done = cyc;
                    busy_at_done = busy;
                end
            end
        end
        prev_sclk = sclk;
        prev_busy = busy;
    end

    task automatic xfer(input int div, input logic [7:0] tx, input logic [7:0] stx,
                        input int sel, input bit keep, input bit poke);
        int         T;
        bit         seen;
        logic [3:0] exp_cs;
        string      p;
        T = div + 1;
        exp_cs = ~(4'b0001 << sel);
        p = poke ? "R8/" : "";
        @(posedge clk); #1;
        n_fall = 0; n_rise = 0; t_busy = -1; t_ff = -1; t_lr = -1; t_done = -1;
        done_w = 0; busy_at_done = 1'b1; cs_at_fall = 4'hF;
        s_tx = stx; s_rx = 8'd0; s_idx = 7;
        clk_div = 8'(div); tx_byte = tx; cs_sel = 2'(sel); keep_cs = keep; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            while (n_fall < 2) begin
                @(negedge clk); #1;
            end
            @(posedge clk); #1;
            start = 1'b1; tx_byte = ~tx; cs_sel = 2'(sel + 1);
            clk_div = 8'(div + 3); keep_cs = ~keep;
            @(posedge clk); #1;
            start = 1'b0;
        end
        seen = 1'b0;
        for (int k = 0; k < 20000 && !seen; k++) begin
            @(negedge clk); #1;
            seen = (done_w > 0);
        end
        repeat (3) @(negedge clk);
        #1;
        check(done_w == 1, {p, "R9 done pulse width"}, done_w, 1);
        check(busy_at_done == 1'b0, {p, "R9 busy low at done"}, int'(busy_at_done), 0);
        check(t_done - t_busy == 17 * T, {p, "R9 transfer length"}, t_done - t_busy, 17 * T);
        check(n_fall == 8, {p, "R2 falling edges"}, n_fall, 8);
        check(n_rise == 8, {p, "R2 rising edges"}, n_rise, 8);
        check(sclk == 1'b1, {p, "R2 idle high after"}, int'(sclk), 1);
        check(t_ff - t_busy == T, {p, "R7 select lead"}, t_ff - t_busy, T);
        check(t_lr - t_ff == 15 * T, {p, "R3 edge spacing"}, t_lr - t_ff, 15 * T);
        check(t_done - t_lr == T, {p, "R7 select trail"}, t_done - t_lr, T);
        check(cs_at_fall == exp_cs, {p, "R6 selected line"}, int'(cs_at_fall), int'(exp_cs));
        if (keep)
            check(cs_n == exp_cs, {p, "R10 select held"}, int'(cs_n), int'(exp_cs));
        else
            check(cs_n == 4'hF, {p, "R10 select released"}, int'(cs_n), 15);
        check(rx_byte == stx, {p, "R5 received byte"}, int'(rx_byte), int'(stx));
        check(s_rx == tx, {p, "R4 transmitted byte"}, int'(s_rx), int'(tx));
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int divs[5] = '{1, 2, 3, 6, 255};
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        check(cs_n == 4'hF, "R1 reset selects", int'(cs_n), 15);
        check(sclk == 1'b1, "R1 reset sclk", int'(sclk), 1);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(rx_byte == 8'd0, "R1 reset rx", int'(rx_byte), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(busy == 1'b0 && sclk == 1'b1, "R1 idle after reset", int'(busy), 0);

        // Exhaustive byte sweep at the fastest divider, rotating selects
        for (int i = 0; i < 256; i++) begin
            xfer(0, 8'(i), 8'(i * 37 + 11), i % 4, 1'b0, (i % 16) == 5);
        end

        // Slower dividers, including the largest
        foreach (divs[j]) begin
            xfer(divs[j], 8'hA5, 8'h3C, j % 4, 1'b0, 1'b0);
            xfer(divs[j], 8'h01, 8'h80, (j + 1) % 4, 1'b0, 1'b1);
        end

        // Held select across two bytes on one line, then released
        xfer(2, 8'hC3, 8'h5E, 2, 1'b1, 1'b0);
        xfer(2, 8'h7E, 8'h81, 2, 1'b0, 1'b0);
        xfer(1, 8'hFF, 8'h00, 3, 1'b1, 1'b1);
        xfer(1, 8'h00, 8'hFF, 0, 1'b0, 1'b0);

        summary();
        $finish;
    end

endmodule